// File: doc/BRIEF.md
# Keyboard Scan-Code Event Decoder

This block sits behind a serial keyboard receiver that has already recovered whole bytes from the wire. Each byte arrives with a one-cycle valid strobe. The block turns the byte stream into key events. Each event carries the key's scan code, a flag for keys from the extended set and a flag that separates press from release. A one-cycle strobe marks each event.

Multi-byte sequences collapse into one event. The extended marker 0xE0 and the release marker 0xF0 are held as pending prefix state until a code byte arrives. A pending prefix that is left hanging is dropped after a programmable number of idle cycles. The block passes no key traffic until the keyboard has reported a successful power-on self-test with the byte 0xAA. It also keeps a held/not-held status for the left and right shift keys, so that downstream logic can resolve shifted characters.

Top module: `kbd_scan_decoder`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `evt_valid`, `evt_code`, `evt_ext`, `evt_release`, `dev_ready`, `shift_left` and `shift_right` are all 0.
- R2: Until the ready flag is set, every byte other than 0xAA is discarded. Such a byte yields no event and leaves no prefix state behind. An accepted 0xAA sets `dev_ready` on the cycle after its valid strobe.
- R3: Once set, `dev_ready` stays set until reset. A later 0xAA yields no event and discards any pending prefix.
- R4: After ready, a byte that is not 0xE0, 0xF0 or 0xAA, with no prefix pending, yields an event on the cycle after its strobe: `evt_valid`=1, `evt_code` equal to the byte, `evt_ext`=0 and `evt_release`=0.
- R5: A 0xF0 byte followed by a code byte yields one event with `evt_release`=1. The 0xF0 byte itself yields no event.
- R6: A 0xE0 byte followed by a code byte yields one event with `evt_ext`=1. The 0xE0 byte itself yields no event.
- R7: The sequence 0xE0, 0xF0, code yields exactly one event, with both `evt_ext` and `evt_release` set.
- R8: Prefix state clears after every event. If an extended key sends two codes, each needs its own 0xE0, and each is reported as a separate tagged event. A code byte with no 0xE0 in front of it is reported with `evt_ext`=0.
- R9: Let a prefix byte be sampled in cycle k and the next byte in cycle k+d. The prefix applies to that byte when d is at most TMO_CYCLES. It is dropped when d is larger.
- R10: A non-extended event with code 0x12 sets `shift_left` on press and clears it on release. Code 0x59 does the same for `shift_right`. Both outputs change in the same cycle as `evt_valid`. Extended events with these codes leave both outputs unchanged.
- R11: `evt_valid` is high for exactly one cycle per event. `evt_code`, `evt_ext`, `evt_release`, `shift_left` and `shift_right` hold their values on every cycle with no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte | input | 8 | Byte from the keyboard receiver |
| rx_valid | input | 1 | One-cycle strobe qualifying rx_byte |
| dev_ready | output | 1 | Self-test byte has been seen |
| evt_valid | output | 1 | One-cycle key event strobe |
| evt_code | output | 8 | Scan code of the last event |
| evt_ext | output | 1 | Last event came from the extended set |
| evt_release | output | 1 | Last event was a key release |
| shift_left | output | 1 | Left shift currently held |
| shift_right | output | 1 | Right shift currently held |

## Verification
The bench builds the decoder with TMO_CYCLES set to 20, with the timer and the shift tracker both enabled. With that value, prefix gaps of 19, 20 and 21 cycles can be driven directly. The bench checks that a prefix survives up to the limit and is dropped one cycle beyond it. The default timeout is sized for a real keyboard's byte spacing and would need far longer runs. Random byte mixes with short and near-limit gaps cover the interleaving of prefixes, shift codes and repeated self-test bytes.

// File: rtl/kbd_scan_pkg.sv
package kbd_scan_pkg;

   localparam int unsigned KB_W = 8;

   typedef logic [KB_W-1:0] kb_byte_t;

   localparam kb_byte_t KB_SELFTEST = 8'hAA;
   localparam kb_byte_t KB_EXT      = 8'hE0;
   localparam kb_byte_t KB_BRK      = 8'hF0;

   // bit 0: extended marker pending, bit 1: release marker pending
   typedef enum logic [1:0] {
      PFX_NONE = 2'b00,
      PFX_EXT  = 2'b01,
      PFX_BRK  = 2'b10,
      PFX_BOTH = 2'b11
   } pfx_e;

   typedef struct packed {
      kb_byte_t code;
      logic     ext;
      logic     rel;
   } kb_evt_t;

endpackage

// File: rtl/kbd_ready_gate.sv
module kbd_ready_gate
   import kbd_scan_pkg::*;
#(
   parameter kb_byte_t SELFTEST = KB_SELFTEST
) (
   input  logic     clk,
   input  logic     rst_n,
   input  kb_byte_t rx_byte_i,
   input  logic     rx_valid_i,
   output logic     ready_o,
   output logic     key_vld_o,
   output logic     reattach_o
);

   logic is_st;

   assign is_st      = (rx_byte_i == SELFTEST);
   assign key_vld_o  = rx_valid_i & ready_o & ~is_st;
   assign reattach_o = rx_valid_i & ready_o & is_st;

   always_ff @(posedge clk) begin
      if (!rst_n)                  ready_o <= 1'b0;
      else if (rx_valid_i && is_st) ready_o <= 1'b1;
   end

   // R3: ready never drops outside reset
   p_ready_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |=> ready_o);

   // R2: ready rises only after a strobed self-test byte
   p_ready_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready_o) |-> $past(rx_valid_i && is_st));

endmodule

// File: rtl/kbd_prefix_fsm.sv
module kbd_prefix_fsm
   import kbd_scan_pkg::*;
#(
   parameter int unsigned TMO_CYCLES = 50000,
   parameter bit          TIMEOUT_EN = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  kb_byte_t rx_byte_i,
   input  logic     key_vld_i,
   input  logic     flush_i,
   output logic     evt_fire_o,
   output kb_evt_t  evt_o
);

   localparam int unsigned TMO_W = $clog2(TMO_CYCLES + 1);

   pfx_e state_q, state_d;
   logic pending;
   logic is_ext, is_brk;
   logic tmo_hit;

   if (TMO_CYCLES < 1) begin : g_bad_tmo
      $error("kbd_prefix_fsm: TMO_CYCLES must be at least 1");
   end

   assign pending = (state_q != PFX_NONE);
   assign is_ext  = (rx_byte_i == KB_EXT);
   assign is_brk  = (rx_byte_i == KB_BRK);

   assign evt_fire_o = key_vld_i & ~is_ext & ~is_brk;
   assign evt_o.code = rx_byte_i;
   assign evt_o.ext  = state_q[0];
   assign evt_o.rel  = state_q[1];

   if (TIMEOUT_EN) begin : g_timer
      localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TMO_CYCLES - 1);
      logic [TMO_W-1:0] idle_q;

      assign tmo_hit = pending & ~key_vld_i & ~flush_i & (idle_q == TMO_LAST);

      always_ff @(posedge clk) begin
         if (!rst_n)                       idle_q <= '0;
         else if (key_vld_i || flush_i)    idle_q <= '0;
         else if (pending) begin
            if (idle_q == TMO_LAST)        idle_q <= '0;
            else                           idle_q <= idle_q + 1'b1;
         end
      end

      // R9: idle count never passes the limit while a prefix waits
      p_idle_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
         pending |-> (idle_q <= TMO_LAST));
   end else begin : g_no_timer
      assign tmo_hit = 1'b0;
   end

   always_comb begin
      state_d = state_q;
      if (flush_i)                 state_d = PFX_NONE;
      else if (key_vld_i) begin
         if (is_ext)               state_d = pfx_e'(state_q | PFX_EXT);
         else if (is_brk)          state_d = pfx_e'(state_q | PFX_BRK);
         else                      state_d = PFX_NONE;
      end
      else if (tmo_hit)            state_d = PFX_NONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= PFX_NONE;
      else        state_q <= state_d;
   end

   // R8: an emitted event leaves no prefix behind
   p_evt_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      evt_fire_o |=> (state_q == PFX_NONE));

   // R3: a repeated self-test byte discards prefixes
   p_flush_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (state_q == PFX_NONE));

endmodule

// File: rtl/kbd_shift_track.sv
module kbd_shift_track
   import kbd_scan_pkg::*;
#(
   parameter bit       TRACK_EN   = 1'b1,
   parameter kb_byte_t LEFT_CODE  = 8'h12,
   parameter kb_byte_t RIGHT_CODE = 8'h59
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    evt_fire_i,
   input  kb_evt_t evt_i,
   output logic    left_o,
   output logic    right_o
);

   if (TRACK_EN) begin : g_track
      if (LEFT_CODE == RIGHT_CODE) begin : g_bad_codes
         $error("kbd_shift_track: shift codes must differ");
      end

      logic upd;
      assign upd = evt_fire_i & ~evt_i.ext;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            left_o  <= 1'b0;
            right_o <= 1'b0;
         end else if (upd) begin
            if (evt_i.code == LEFT_CODE)  left_o  <= ~evt_i.rel;
            if (evt_i.code == RIGHT_CODE) right_o <= ~evt_i.rel;
         end
      end

      // R10: shift status moves only on a non-extended event
      p_shift_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
         !($stable(left_o) && $stable(right_o)) |-> $past(evt_fire_i && !evt_i.ext));
   end else begin : g_no_track
      assign left_o  = 1'b0;
      assign right_o = 1'b0;
   end

endmodule

// File: rtl/kbd_scan_decoder.sv
module kbd_scan_decoder
   import kbd_scan_pkg::*;
#(
   parameter int unsigned TMO_CYCLES  = 50000,
   parameter bit          TIMEOUT_EN  = 1'b1,
   parameter bit          SHIFT_EN    = 1'b1,
   parameter logic [7:0]  LSHIFT_CODE = 8'h12,
   parameter logic [7:0]  RSHIFT_CODE = 8'h59
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] rx_byte,
   input  logic       rx_valid,
   output logic       dev_ready,
   output logic       evt_valid,
   output logic [7:0] evt_code,
   output logic       evt_ext,
   output logic       evt_release,
   output logic       shift_left,
   output logic       shift_right
);

   logic    key_vld, reattach, fire;
   kb_evt_t evt_c, evt_q;

   kbd_ready_gate #(.SELFTEST(KB_SELFTEST)) ready_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_byte_i  (rx_byte),
      .rx_valid_i (rx_valid),
      .ready_o    (dev_ready),
      .key_vld_o  (key_vld),
      .reattach_o (reattach)
   );

   kbd_prefix_fsm #(.TMO_CYCLES(TMO_CYCLES), .TIMEOUT_EN(TIMEOUT_EN)) pfx_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_byte_i  (rx_byte),
      .key_vld_i  (key_vld),
      .flush_i    (reattach),
      .evt_fire_o (fire),
      .evt_o      (evt_c)
   );

   kbd_shift_track #(
      .TRACK_EN   (SHIFT_EN),
      .LEFT_CODE  (LSHIFT_CODE),
      .RIGHT_CODE (RSHIFT_CODE)
   ) shift_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_fire_i (fire),
      .evt_i      (evt_c),
      .left_o     (shift_left),
      .right_o    (shift_right)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         evt_valid <= 1'b0;
         evt_q     <= '0;
      end else begin
         evt_valid <= fire;
         if (fire) evt_q <= evt_c;
      end
   end

   assign evt_code    = evt_q.code;
   assign evt_ext     = evt_q.ext;
   assign evt_release = evt_q.rel;

   // R11: every event is tied to a strobed byte
   p_evt_after_byte_r11: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |-> $past(rx_valid));

   // R11: event fields hold between events
   p_evt_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_valid |-> ($stable(evt_code) && $stable(evt_ext) && $stable(evt_release)));

   // R2: no key traffic before the self-test byte
   p_evt_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |-> dev_ready);

   // R11: shift status holds between events
   p_shift_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_valid |-> ($stable(shift_left) && $stable(shift_right)));

endmodule

// File: tb/kbd_scan_decoder_tb_top.sv
module kbd_scan_decoder_tb_top;

   localparam int T = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] rx_byte = 8'h00;
   logic       rx_valid = 1'b0;
   logic       dev_ready, evt_valid, evt_ext, evt_release, shift_left, shift_right;
   logic [7:0] evt_code;

   int n_chk = 0;
   int n_bad = 0;

   // reference model state
   bit         m_rdy, m_ext, m_brk, m_e, m_r, m_sl, m_sr;
   logic [7:0] m_code;

   always #4 clk = ~clk;

   kbd_scan_decoder #(.TMO_CYCLES(T)) dut_i (
      .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
      .dev_ready(dev_ready), .evt_valid(evt_valid), .evt_code(evt_code),
      .evt_ext(evt_ext), .evt_release(evt_release),
      .shift_left(shift_left), .shift_right(shift_right)
   );

   function automatic logic [13:0] expect_vec(bit v);
      return {v, m_code, m_e, m_r, m_rdy, m_sl, m_sr};
   endfunction

   task automatic chk(string tag, bit exp_v);
      logic [13:0] act, exp;
      act = {evt_valid, evt_code, evt_ext, evt_release, dev_ready, shift_left, shift_right};
      exp = expect_vec(exp_v);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: act=%h exp=%h (valid,code,ext,rel,rdy,sl,sr) t=%0t",
                  tag, act, exp, $time);
      end
   endtask

   task automatic idle(int g);
      for (int i = 0; i < g; i++) begin
         rx_valid = 1'b0;
         @(negedge clk);
         chk("R11", 1'b0);
      end
   endtask

   // waits g idle cycles, then strobes byte b for one cycle and checks the result
   task automatic put(logic [7:0] b, int g, string tag);
      bit ev;
      idle(g);
      ev = 1'b0;
      if ((m_ext || m_brk) && g >= T) begin
         m_ext = 1'b0; m_brk = 1'b0;
      end
      if (!m_rdy) begin
         if (b == 8'hAA) m_rdy = 1'b1;
      end else if (b == 8'hAA) begin
         m_ext = 1'b0; m_brk = 1'b0;
      end else if (b == 8'hE0) begin
         m_ext = 1'b1;
      end else if (b == 8'hF0) begin
         m_brk = 1'b1;
      end else begin
         ev = 1'b1;
         m_code = b; m_e = m_ext; m_r = m_brk;
         if (!m_ext) begin
            if (b == 8'h12) m_sl = !m_brk;
            if (b == 8'h59) m_sr = !m_brk;
         end
         m_ext = 1'b0; m_brk = 1'b0;
      end
      rx_byte  = b;
      rx_valid = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0;
      chk(tag, ev);
   endtask

   function automatic logic [7:0] pick_byte();
      int k;
      k = int'($urandom_range(0, 15));
      case (k)
         0, 1, 2: return 8'hE0;
         3, 4, 5: return 8'hF0;
         6, 7:    return 8'h12;
         8:       return 8'h59;
         9:       return (($urandom_range(0, 7) == 0) ? 8'hAA : 8'h1C);
         default: return 8'($urandom_range(1, 8'hDF));
      endcase
   endfunction

   function automatic int pick_gap();
      int k;
      k = int'($urandom_range(0, 19));
      if (k == 0)      return T - 1;
      else if (k == 1) return T;
      else if (k == 2) return T + 1;
      else             return int'($urandom_range(0, 3));
   endfunction

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: act=running exp=finished");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      m_rdy = 0; m_ext = 0; m_brk = 0; m_e = 0; m_r = 0; m_sl = 0; m_sr = 0; m_code = 8'h00;

      // R1: reset state, during and just after reset
      repeat (3) @(negedge clk);
      chk("R1", 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", 1'b0);

      // R2: traffic before self-test ignored, prefixes leave nothing behind
      put(8'h1C, 0, "R2");
      put(8'hE0, 1, "R2");
      put(8'hF0, 0, "R2");
      put(8'hAA, 2, "R2");
      put(8'h1C, 0, "R2");

      // R4: plain presses, back to back and spaced
      put(8'h32, 0, "R4");
      put(8'h21, 3, "R4");

      // R5: release
      put(8'hF0, 0, "R5");
      put(8'h21, 0, "R5");

      // R6: extended press
      put(8'hE0, 1, "R6");
      put(8'h75, 0, "R6");

      // R7: extended release
      put(8'hE0, 0, "R7");
      put(8'hF0, 0, "R7");
      put(8'h75, 0, "R7");

      // R8: two-code extended action, then bare code
      put(8'hE0, 0, "R8");
      put(8'h12, 0, "R8");
      put(8'hE0, 0, "R8");
      put(8'h7C, 0, "R8");
      put(8'h7C, 0, "R8");

      // R10: shift make/break, extended look-alike ignored
      put(8'h12, 0, "R10");
      put(8'h59, 0, "R10");
      put(8'hE0, 0, "R10");
      put(8'hF0, 0, "R10");
      put(8'h12, 0, "R10");
      put(8'hF0, 0, "R10");
      put(8'h12, 0, "R10");
      put(8'hF0, 0, "R10");
      put(8'h59, 0, "R10");

      // R9: timeout boundary
      put(8'hE0, 0, "R9");
      put(8'h6B, T - 1, "R9");
      put(8'hE0, 0, "R9");
      put(8'h6B, T, "R9");
      put(8'hF0, 0, "R9");
      put(8'h1C, T + 1, "R9");

      // R3: repeated self-test flushes prefix, ready sticks
      put(8'hE0, 0, "R3");
      put(8'hF0, 0, "R3");
      put(8'hAA, 0, "R3");
      put(8'h1C, 0, "R3");

      // R11: random mix
      for (int i = 0; i < 600; i++) begin
         int g;
         logic [7:0] b;
         g = pick_gap();
         b = pick_byte();
         put(b, g, "R11");
      end

      idle(3);
      summary();
      $finish;
   end

endmodule